// File: doc/BRIEF.md
# Cascaded Quadrature Position Counter

This block turns a pair of quadrature phase signals into a 32-bit signed-direction position count. It does this with two chained 16-bit counters. The lower counter is driven by a quadrature decoder. The decoder samples both phase inputs through a synchronizer and counts once on every edge of either input. The direction of each count comes from the level of the other input at that moment.

The upper counter has no count source of its own. It takes one step up each time the lower counter wraps forward from all-ones to zero. It takes one step down each time the lower counter wraps backward from zero to all-ones. Taken together, the pair behaves as one wide position register that software can preload, half by half, through two write ports.

Top module: `quad_cascade_counter`

## Requirements
- R1: While `rst` is high at a clock edge, both counters clear to 0x0000 and the synchronized phase history clears to A=0, B=0.
- R2: A valid edge in the forward direction adds one to the lower count. The forward edges are: A rising with B low, B rising with A high, A falling with B high, and B falling with A low. The new value appears on `lo_count` at the third rising clock edge after the input change.
- R3: A valid edge in the reverse direction subtracts one from the lower count. The reverse edges are: A rising with B high, B rising with A low, A falling with B low, and B falling with A high.
- R4: If both phase inputs change between the same two synchronized samples, the transition is invalid and neither counter moves.
- R5: The lower count wraps from 0xFFFF to 0x0000 when it counts up, and from 0x0000 to 0xFFFF when it counts down.
- R6: Each forward wrap of the lower count adds one to `hi_count` on the same clock edge.
- R7: Each reverse wrap of the lower count subtracts one from `hi_count` on the same clock edge.
- R8: When the lower count changes without wrapping, or does not change, `hi_count` keeps its value.
- R9: `hi_count` wraps modulo 2^16: it goes from 0xFFFF to 0x0000 on a forward wrap and from 0x0000 to 0xFFFF on a reverse wrap.
- R10: A write to a counter loads its data on that clock edge and overrides any count in the same cycle. A lower write also cancels the wrap that count would have caused. An upper write overrides a wrap arriving from below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_a_in | input | 1 | Quadrature phase A, asynchronous |
| phase_b_in | input | 1 | Quadrature phase B, asynchronous |
| wr_lo_en | input | 1 | Load strobe for the lower counter |
| wr_lo_data | input | 16 | Value for the lower counter |
| wr_hi_en | input | 1 | Load strobe for the upper counter |
| wr_hi_data | input | 16 | Value for the upper counter |
| lo_count | output | 16 | Lower counter value |
| hi_count | output | 16 | Upper counter value |

## Verification
The decoder is driven with random walks that mix forward steps, reverse steps and simultaneous double toggles. These walks separate the direction table for all eight single-edge cases from the rejection of invalid moves, and every result is compared against a 32-bit reference position. Directed runs preload the lower half near 0xFFFF or 0x0000 and step across the boundary, which separates a carry from a borrow and exposes any wrap of the upper half. Loads issued in the exact cycle a step lands show whether a write really takes priority and whether it suppresses the carry.

// File: rtl/qc_pkg.sv
package qc_pkg;
  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DN   = 2'd2
  } step_e;
endpackage

// File: rtl/qc_sync.sv
module qc_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= '0;
        else if (i == 0) chain[i] <= d;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/qc_decoder.sv
module qc_decoder
  import qc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  a_s,
  input  logic  b_s,
  output step_e step
);
  logic a_prev, b_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_prev <= 1'b0;
      b_prev <= 1'b0;
    end else begin
      a_prev <= a_s;
      b_prev <= b_s;
    end
  end

  logic a_chg, b_chg;
  assign a_chg = a_s ^ a_prev;
  assign b_chg = b_s ^ b_prev;

  always_comb begin
    step = STEP_NONE;
    if (a_chg && !b_chg)      step = (a_s ^ b_s) ? STEP_UP : STEP_DN;
    else if (b_chg && !a_chg) step = (a_s ~^ b_s) ? STEP_UP : STEP_DN;
  end

  // R4: a double change never produces a step
  p_invalid_none_r4: assert property (@(posedge clk) disable iff (rst)
    (a_chg && b_chg) |-> (step == STEP_NONE));
endmodule

// File: rtl/qc_stage.sv
module qc_stage
  import qc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  step_e        step,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] count,
  output logic         wrap_up,
  output logic         wrap_dn
);
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  assign wrap_up = !wr_en && (step == STEP_UP) && (count == ALL_ONES);
  assign wrap_dn = !wr_en && (step == STEP_DN) && (count == '0);

  always_ff @(posedge clk) begin
    if (rst)                   count <= '0;
    else if (wr_en)            count <= wr_data;
    else if (step == STEP_UP)  count <= count + 1'b1;
    else if (step == STEP_DN)  count <= count - 1'b1;
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (step == STEP_NONE && !wr_en) |=> $stable(count));
  p_write_prio_r10: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (count == $past(wr_data)));
  p_wrap_up_r5: assert property (@(posedge clk) disable iff (rst)
    wrap_up |=> (count == '0));
  p_wrap_dn_r5: assert property (@(posedge clk) disable iff (rst)
    wrap_dn |=> (count == ALL_ONES));
endmodule

// File: rtl/quad_cascade_counter.sv
module quad_cascade_counter
  import qc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             phase_a_in,
  input  logic             phase_b_in,
  input  logic             wr_lo_en,
  input  logic [CNT_W-1:0] wr_lo_data,
  input  logic             wr_hi_en,
  input  logic [CNT_W-1:0] wr_hi_data,
  output logic [CNT_W-1:0] lo_count,
  output logic [CNT_W-1:0] hi_count
);
  logic [1:0] ph_s;
  step_e      lo_step, hi_step;
  logic       lo_wrap_up, lo_wrap_dn, hi_wrap_up, hi_wrap_dn;

  qc_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({phase_a_in, phase_b_in}), .q(ph_s));

  qc_decoder u_dec (
    .clk(clk), .rst(rst), .a_s(ph_s[1]), .b_s(ph_s[0]), .step(lo_step));

  qc_stage #(.W(CNT_W)) u_lo (
    .clk(clk), .rst(rst), .step(lo_step), .wr_en(wr_lo_en),
    .wr_data(wr_lo_data), .count(lo_count),
    .wrap_up(lo_wrap_up), .wrap_dn(lo_wrap_dn));

  always_comb begin
    if (lo_wrap_up)      hi_step = STEP_UP;
    else if (lo_wrap_dn) hi_step = STEP_DN;
    else                 hi_step = STEP_NONE;
  end

  qc_stage #(.W(CNT_W)) u_hi (
    .clk(clk), .rst(rst), .step(hi_step), .wr_en(wr_hi_en),
    .wr_data(wr_hi_data), .count(hi_count),
    .wrap_up(hi_wrap_up), .wrap_dn(hi_wrap_dn));

  p_carry_r6: assert property (@(posedge clk) disable iff (rst)
    (lo_wrap_up && !wr_hi_en) |=> (hi_count == $past(hi_count) + 1'b1));
  p_borrow_r7: assert property (@(posedge clk) disable iff (rst)
    (lo_wrap_dn && !wr_hi_en) |=> (hi_count == $past(hi_count) - 1'b1));
  p_hi_wrap_up_r9: assert property (@(posedge clk) disable iff (rst)
    hi_wrap_up |=> (hi_count == '0));
  p_hi_wrap_dn_r9: assert property (@(posedge clk) disable iff (rst)
    hi_wrap_dn |=> (hi_count == {CNT_W{1'b1}}));
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (lo_count == '0 && hi_count == '0));
endmodule

// File: tb/quad_cascade_counter_tb.sv
module quad_cascade_counter_tb;
  logic clk = 0, rst = 1;
  logic phase_a_in = 0, phase_b_in = 0;
  logic wr_lo_en = 0, wr_hi_en = 0;
  logic [15:0] wr_lo_data = 0, wr_hi_data = 0;
  logic [15:0] lo_count, hi_count;

  int n_chk = 0, n_fail = 0;
  logic [31:0] pos = 0;
  bit done = 0;

  always #2 clk = ~clk;

  quad_cascade_counter u_dut (.*);

  function automatic logic [1:0] fwd(input logic [1:0] ab);
    case (ab)
      2'b00: return 2'b10;
      2'b10: return 2'b11;
      2'b11: return 2'b01;
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic [1:0] rev(input logic [1:0] ab);
    case (ab)
      2'b00: return 2'b01;
      2'b01: return 2'b11;
      2'b11: return 2'b10;
      default: return 2'b00;
    endcase
  endfunction

  task automatic check(input string req);
    n_chk++;
    if ({hi_count, lo_count} !== pos) begin
      n_fail++;
      $display("FAIL %s: hi/lo=%h_%h expected %h_%h", req, hi_count, lo_count,
               pos[31:16], pos[15:0]);
    end
  endtask

  // kind 0 forward, 1 reverse, 2 both toggle
  task automatic move(input int kind, input string req);
    logic [1:0] cur, nxt;
    cur = {phase_a_in, phase_b_in};
    nxt = (kind == 0) ? fwd(cur) : (kind == 1) ? rev(cur) : ~cur;
    @(negedge clk);
    {phase_a_in, phase_b_in} = nxt;
    repeat (4) @(negedge clk);
    if (kind == 0) pos = pos + 1;
    else if (kind == 1) pos = pos - 1;
    check(req);
  endtask

  task automatic load(input logic [31:0] v);
    @(negedge clk);
    wr_lo_en = 1; wr_hi_en = 1;
    wr_lo_data = v[15:0]; wr_hi_data = v[31:16];
    @(negedge clk);
    wr_lo_en = 0; wr_hi_en = 0;
    pos = v;
  endtask

  // write lands on the same edge as a step (R10)
  task automatic move_with_write(input int kind, input bit hi_side,
                                 input logic [15:0] d, input string req);
    logic [1:0] cur;
    cur = {phase_a_in, phase_b_in};
    @(negedge clk);
    {phase_a_in, phase_b_in} = (kind == 0) ? fwd(cur) : rev(cur);
    repeat (2) @(negedge clk);
    if (hi_side) begin wr_hi_en = 1; wr_hi_data = d; end
    else begin wr_lo_en = 1; wr_lo_data = d; end
    @(negedge clk);
    wr_hi_en = 0; wr_lo_en = 0;
    repeat (2) @(negedge clk);
    if (hi_side) begin
      pos[15:0] = (kind == 0) ? pos[15:0] + 16'd1 : pos[15:0] - 16'd1;
      pos[31:16] = d;
    end else pos[15:0] = d;
    check(req);
  endtask

  initial begin
    #(4ns * 200000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 reset");
    // R2 all four forward edges, R3 all four reverse edges
    for (int i = 0; i < 4; i++) move(0, "R2 forward");
    for (int i = 0; i < 4; i++) move(1, "R3 reverse");
    // R4 invalid double toggles
    move(2, "R4 invalid");
    move(2, "R4 invalid");
    // R5/R6 forward wrap with carry, R8 hold otherwise
    load(32'h0005_FFFE);
    move(0, "R8 no carry");
    move(0, "R5 R6 carry");
    move(1, "R5 R7 borrow");
    move(1, "R8 hold");
    // R9 upper wrap both ways
    load(32'hFFFF_FFFF);
    move(0, "R9 hi wrap up");
    move(1, "R9 hi wrap down");
    // R10 priority
    load(32'h0010_FFFF);
    move_with_write(0, 0, 16'h1234, "R10 lo write beats step");
    load(32'h0010_FFFF);
    move_with_write(0, 1, 16'hABCD, "R10 hi write beats carry");
    load(32'h0020_0000);
    move_with_write(1, 1, 16'h0042, "R10 hi write beats borrow");
    // random walk near a boundary
    load(32'h7FFF_FFF8);
    for (int i = 0; i < 300; i++) begin
      int r;
      r = $urandom_range(0, 9);
      move(r < 5 ? 0 : (r < 9 ? 1 : 2), "R2 R3 R4 random walk");
    end
    rst = 1;
    @(negedge clk);
    rst = 0;
    {phase_a_in, phase_b_in} = 2'b00;
    pos = 0;
    repeat (3) @(negedge clk);
    check("R1 reset after run");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule